// File: doc/BRIEF.md
# Filtered Horizontal Line Resampler

This block resizes one line of 8-bit video at a time by an arbitrary ratio. The output line length is set independently of the input line length, so the same hardware enlarges or reduces. Resampling uses an integer error accumulator instead of a multiplier. When enlarging, it repeats the current input position until the error term crosses the output length. When reducing, it steps over input positions until an output falls due.

A selectable three-tap horizontal filter either sharpens or smooths the line. Its place relative to the resampler depends on the filter family and the scaling direction. When enlarging, a sharpening kernel works on the input neighbours and a smoothing kernel works on neighbouring resampled values, where it acts as an interpolator. When reducing, smoothing works on the input as a band limiter and sharpening works on the resampled values.

Samples enter as a valid/ready stream. A start-of-line flag marks the first sample of each line. Each line is gathered into a line store, and then its resampled values leave on a stream that carries only a valid flag. Both line lengths must lie between 1 and `MAX_LEN`.

Top module: `vscale_line`

## Requirements
- R1: A sample is taken at a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high after reset and while a line is being gathered. It is low from the edge that takes a line's last sample until the edge after that line's last resampled position is issued. A sample taken without `in_sol` while no line is open is discarded and causes no output.
- R2: Every gathered line produces exactly `cfg_out_len` output samples, in output order.
- R3: With filter code 0, 6 or 7, output k (counted from 0) equals the input sample at position floor(k*in_len/out_len). Position 0 is the sample that carried `in_sol`.
- R4: When enlarging (out_len >= in_len), the outputs of a line appear on consecutive clock cycles.
- R5: When reducing (out_len < in_len) with the filter off, the block advances one input position per clock. The cycle gap between outputs k and k+1 is therefore floor((k+1)*in_len/out_len) - floor(k*in_len/out_len).
- R6: The filter codes select these kernels, with the weights in quarters given as (left, centre, right): 1 = (-2, 8, -2), 2 = (-4, 12, -4), 3 = (-8, 20, -8), 4 = (1, 2, 1), 5 = (2, 0, 2). Codes 1 to 3 are the sharpening family and codes 4 and 5 are the smoothing family.
- R7: A filtered value is the weighted sum plus 2, divided by 4 and rounded toward minus infinity, then clamped to the range 0..255.
- R8: Sharpening works on input neighbours when enlarging and on neighbouring resampled values when reducing. Smoothing works on input neighbours when reducing and on neighbouring resampled values when enlarging.
- R9: At both ends of a line, the missing neighbour tap takes the value of the end sample. This applies to input neighbours and to resampled neighbours alike.
- R10: Lengths and the filter code are sampled in the cycle that takes `in_sol`, so later changes have no effect on that line. An `in_sol` taken while a line is still being gathered restarts gathering at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_in_len | input | $clog2(MAX_LEN+1) | Input samples per line, 1..MAX_LEN |
| cfg_out_len | input | $clog2(MAX_LEN+1) | Output samples per line, 1..MAX_LEN |
| cfg_filter | input | 3 | Filter code, see R6 |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts a sample |
| in_sol | input | 1 | Sample is the first of a line |
| in_data | input | 8 | Input sample |
| out_valid | output | 1 | Output sample present |
| out_data | output | 8 | Output sample |

## Verification
Two events can land on the same clock edge. One is the trailing output of a line whose filter works on resampled values; it leaves one cycle after the last resampled position. The other is the acceptance of the next line's start-of-line sample. The bench provokes this by driving each new line the moment `in_ready` returns, with no idle gap. It judges the result by comparing the whole output stream, sample by sample, with an arithmetic model of floor-index mapping, edge replication and kernels. A lost trailing sample, or a corrupted first sample of the next line, shows up as a shifted or wrong value.

// File: rtl/vscale_pkg.sv
package vscale_pkg;

  function automatic logic is_sharp(input logic [2:0] f);
    return (f == 3'd1) || (f == 3'd2) || (f == 3'd3);
  endfunction

  function automatic logic is_smooth(input logic [2:0] f);
    return (f == 3'd4) || (f == 3'd5);
  endfunction

  // filter on input neighbours (before the resampler)
  function automatic logic place_pre(input logic [2:0] f, input logic enl);
    return (is_sharp(f) && enl) || (is_smooth(f) && !enl);
  endfunction

  // filter on resampled neighbours (after the resampler)
  function automatic logic place_post(input logic [2:0] f, input logic enl);
    return (is_sharp(f) && !enl) || (is_smooth(f) && enl);
  endfunction

  // three-tap kernel in quarter weights, rounded then clamped
  function automatic logic [7:0] tap3(input logic [2:0] f, input logic [7:0] a,
                                      input logic [7:0] b, input logic [7:0] c);
    logic signed [14:0] sa, sb, sc, acc;
    sa = $signed({7'd0, a});
    sb = $signed({7'd0, b});
    sc = $signed({7'd0, c});
    case (f)
      3'd1:    acc = (sb <<< 3) - (sa <<< 1) - (sc <<< 1);
      3'd2:    acc = (sb <<< 3) + (sb <<< 2) - (sa <<< 2) - (sc <<< 2);
      3'd3:    acc = (sb <<< 4) + (sb <<< 2) - (sa <<< 3) - (sc <<< 3);
      3'd4:    acc = sa + (sb <<< 1) + sc;
      3'd5:    acc = (sa <<< 1) + (sc <<< 1);
      default: acc = sb <<< 2;
    endcase
    acc = acc + 15'sd2;
    if (acc < 15'sd0)         return 8'd0;
    else if (acc > 15'sd1023) return 8'd255;
    else                      return acc[9:2];
  endfunction

endpackage

// File: rtl/vscale_linebuf.sv
module vscale_linebuf #(
  parameter int DEPTH = 64,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [IW-1:0] rd_idx,
  input  logic [IW-1:0] last_idx,
  output logic [7:0]    tap_l,
  output logic [7:0]    tap_c,
  output logic [7:0]    tap_r
);

  logic [7:0] store [DEPTH];
  logic [IW-1:0] idx_l, idx_r;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // edge replication of the missing neighbour
  always_comb begin
    idx_l = (rd_idx == '0) ? rd_idx : rd_idx - IW'(1);
    idx_r = (rd_idx >= last_idx) ? last_idx : rd_idx + IW'(1);
  end

  assign tap_l = store[idx_l];
  assign tap_c = store[rd_idx];
  assign tap_r = store[idx_r];

endmodule

// File: rtl/vscale_stepper.sv
module vscale_stepper #(
  parameter int LW = 7,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] in_len,
  input  logic [LW-1:0] out_len,
  output logic          busy,
  output logic          emit,
  output logic          last,
  output logic [IW-1:0] idx
);

  logic          busy_q;
  logic [IW-1:0] pos_q;
  logic [LW-1:0] done_q;
  logic [LW:0]   err_q;
  logic          enl;
  logic [LW:0]   err_up;

  assign enl    = (out_len >= in_len);
  assign err_up = err_q + {1'b0, in_len};
  assign busy   = busy_q;
  assign idx    = pos_q;
  assign emit   = busy_q & (enl | (err_q < {1'b0, out_len}));
  assign last   = emit & (done_q == out_len - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      done_q <= '0;
      err_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      pos_q  <= '0;
      done_q <= '0;
      err_q  <= '0;
    end else if (busy_q) begin
      if (enl) begin
        // repeat the position until the error term crosses out_len
        done_q <= done_q + LW'(1);
        if (err_up >= {1'b0, out_len}) begin
          err_q <= err_up - {1'b0, out_len};
          pos_q <= pos_q + IW'(1);
        end else begin
          err_q <= err_up;
        end
      end else begin
        // one input position per cycle, emit only when due
        pos_q <= pos_q + IW'(1);
        if (emit) begin
          err_q  <= err_up - {1'b0, out_len};
          done_q <= done_q + LW'(1);
        end else begin
          err_q <= err_q - {1'b0, out_len};
        end
      end
      if (last) busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/vscale_post3.sv
module vscale_post3 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_v,
  input  logic       in_last,
  input  logic [7:0] in_data,
  input  logic       post_en,
  input  logic [2:0] flt,
  output logic       out_v,
  output logic [7:0] out_data,
  output logic       flush_pend
);
  import vscale_pkg::*;

  logic       have_q, flush_q;
  logic [7:0] prev_q, cur_q;
  logic [2:0] flt_q;

  assign flush_pend = flush_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v    <= 1'b0;
      out_data <= '0;
      have_q   <= 1'b0;
      flush_q  <= 1'b0;
      prev_q   <= '0;
      cur_q    <= '0;
      flt_q    <= '0;
    end else begin
      out_v <= 1'b0;
      if (flush_q) begin
        // trailing output: right tap replicates the end sample
        out_v    <= 1'b1;
        out_data <= tap3(flt_q, prev_q, cur_q, cur_q);
        flush_q  <= 1'b0;
        have_q   <= 1'b0;
      end else if (in_v) begin
        if (!post_en) begin
          out_v    <= 1'b1;
          out_data <= in_data;
        end else begin
          flt_q <= flt;
          if (!have_q) begin
            prev_q <= in_data;
            cur_q  <= in_data;
            have_q <= 1'b1;
          end else begin
            out_v    <= 1'b1;
            out_data <= tap3(flt, prev_q, cur_q, in_data);
            prev_q   <= cur_q;
            cur_q    <= in_data;
          end
          if (in_last) flush_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vscale_line.sv
module vscale_line #(
  parameter int MAX_LEN = 64,
  localparam int IW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cfg_in_len,
  input  logic [LW-1:0] cfg_out_len,
  input  logic [2:0]    cfg_filter,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sol,
  input  logic [7:0]    in_data,
  output logic          out_valid,
  output logic [7:0]    out_data
);
  import vscale_pkg::*;

  typedef enum logic {ST_GATHER, ST_ISSUE} st_e;

  st_e           st_q;
  logic          line_open_q;
  logic [LW-1:0] wcnt_q, in_len_q, out_len_q;
  logic [2:0]    flt_q;

  logic          take, take_sol, take_more, load_done;
  logic [LW-1:0] cnt_nx, len_now;
  logic [IW-1:0] wr_addr, last_idx;
  logic          step_busy, step_emit, step_last;
  logic [IW-1:0] step_idx;
  logic [7:0]    tap_l, tap_c, tap_r, pre_val;
  logic          enlarge, use_pre, use_post, flush_pend;

  assign in_ready  = (st_q == ST_GATHER);
  assign take      = in_valid & in_ready;
  assign take_sol  = take & in_sol;
  assign take_more = take & ~in_sol & line_open_q;
  assign cnt_nx    = take_sol ? LW'(1) : wcnt_q + LW'(1);
  assign len_now   = take_sol ? cfg_in_len : in_len_q;
  assign load_done = (take_sol | take_more) & (cnt_nx == len_now);
  assign wr_addr   = take_sol ? '0 : wcnt_q[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_GATHER;
      line_open_q <= 1'b0;
      wcnt_q      <= '0;
      in_len_q    <= LW'(1);
      out_len_q   <= LW'(1);
      flt_q       <= '0;
    end else begin
      if (take_sol) begin
        in_len_q    <= cfg_in_len;
        out_len_q   <= cfg_out_len;
        flt_q       <= cfg_filter;
        line_open_q <= 1'b1;
        wcnt_q      <= cnt_nx;
      end else if (take_more) begin
        wcnt_q <= cnt_nx;
      end
      if (load_done) begin
        st_q        <= ST_ISSUE;
        line_open_q <= 1'b0;
      end else if (st_q == ST_ISSUE && step_last) begin
        st_q <= ST_GATHER;
      end
    end
  end

  vscale_linebuf #(.DEPTH(MAX_LEN), .IW(IW)) u_buf (
    .clk      (clk),
    .wr_en    (take_sol | take_more),
    .wr_addr  (wr_addr),
    .wr_data  (in_data),
    .rd_idx   (step_idx),
    .last_idx (last_idx),
    .tap_l    (tap_l),
    .tap_c    (tap_c),
    .tap_r    (tap_r)
  );

  assign last_idx = IW'(in_len_q - LW'(1));

  vscale_stepper #(.LW(LW), .IW(IW)) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (load_done),
    .in_len  (in_len_q),
    .out_len (out_len_q),
    .busy    (step_busy),
    .emit    (step_emit),
    .last    (step_last),
    .idx     (step_idx)
  );

  assign enlarge  = (out_len_q >= in_len_q);
  assign use_pre  = place_pre(flt_q, enlarge);
  assign use_post = place_post(flt_q, enlarge);
  assign pre_val  = use_pre ? tap3(flt_q, tap_l, tap_c, tap_r) : tap_c;

  vscale_post3 u_post (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_v       (step_emit),
    .in_last    (step_last),
    .in_data    (pre_val),
    .post_en    (use_post),
    .flt        (flt_q),
    .out_v      (out_valid),
    .out_data   (out_data),
    .flush_pend (flush_pend)
  );

endmodule

// File: rtl/vscale_line_chk.sv
module vscale_line_chk #(
  parameter int LW = 7,
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          step_busy,
  input logic          step_emit,
  input logic          step_last,
  input logic [IW-1:0] step_idx,
  input logic [LW-1:0] in_len_q,
  input logic [LW-1:0] out_len_q,
  input logic          enlarge,
  input logic          flush_pend,
  input logic          load_done
);

  int emit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         emit_cnt <= 0;
    else if (load_done) emit_cnt <= 0;
    else if (step_emit) emit_cnt <= emit_cnt + 1;
  end

  a_r1_no_take_while_issuing: assert property (@(posedge clk) disable iff (!rst_n)
    step_busy |-> !in_ready);

  a_r2_exact_count: assert property (@(posedge clk) disable iff (!rst_n)
    step_emit |-> (step_last == (emit_cnt == int'(out_len_q) - 1)));

  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_emit |-> (int'(step_idx) < int'(in_len_q)));

  a_r4_enlarge_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (step_busy && enlarge) |-> step_emit);

  a_r5_pos_step_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (step_busy && $past(step_busy)) |->
      (int'(step_idx) == int'($past(step_idx)) || int'(step_idx) == int'($past(step_idx)) + 1));

  a_r9_trailing_output: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pend |=> out_valid);

endmodule

bind vscale_line vscale_line_chk #(.LW(LW), .IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .step_busy  (step_busy),
  .step_emit  (step_emit),
  .step_last  (step_last),
  .step_idx   (step_idx),
  .in_len_q   (in_len_q),
  .out_len_q  (out_len_q),
  .enlarge    (enlarge),
  .flush_pend (flush_pend),
  .load_done  (load_done)
);

// File: tb/vscale_line_test.sv
`timescale 1ns/1ps
module vscale_line_test;
  localparam int ML = 16;
  localparam int LW = $clog2(ML + 1);
  localparam int QN = 32768;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [LW-1:0] cfg_in_len, cfg_out_len;
  logic [2:0]    cfg_filter;
  logic          in_valid, in_sol, in_ready, out_valid;
  logic [7:0]    in_data, out_data;

  always #4 clk = ~clk;

  vscale_line #(.MAX_LEN(ML)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_in_len(cfg_in_len), .cfg_out_len(cfg_out_len),
    .cfg_filter(cfg_filter), .in_valid(in_valid), .in_ready(in_ready), .in_sol(in_sol),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  int errors = 0, checks = 0, cyc = 0;
  int exp_q [QN];
  int tag_q [QN];
  int got_cyc [QN];
  int wr = 0, rd = 0;
  int line_buf [ML];
  bit finished = 0;

  function automatic string tname(int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, expv, $time);
    end
  endtask

  // R6 / R7 arithmetic model
  function automatic int kern(int f, int a, int b, int c);
    int s;
    case (f)
      1: s = 8*b - 2*a - 2*c;
      2: s = 12*b - 4*a - 4*c;
      3: s = 20*b - 8*a - 8*c;
      4: s = a + 2*b + c;
      5: s = 2*a + 2*c;
      default: return b;
    endcase
    s = s + 2;
    if (s < 0) return 0;
    s = s / 4;
    return (s > 255) ? 255 : s;
  endfunction

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic int rsm(int j, int nin, int nout);
    return line_buf[(clampi(j, 0, nout-1) * nin) / nout];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<190000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd >= wr) begin
        chk(0, "R2 extra output", int'(out_data), -1);
      end else begin
        chk(int'(out_data) == exp_q[rd], tname(tag_q[rd]), int'(out_data), exp_q[rd]);
        got_cyc[rd] = cyc;
        rd++;
      end
    end
  end

  task automatic send_line(input int nin, input int nout, input int f, input int tag_ovr, input bit mess);
    int pat;
    bit sharp, smooth, pre, post;
    pat = (nin + nout + f) % 3;
    for (int j = 0; j < nin; j++) begin
      if (pat == 0)      line_buf[j] = (j % 2 == 0) ? 0 : 255;
      else if (pat == 1) line_buf[j] = (j*37 + nin*11 + nout*5) % 256;
      else               line_buf[j] = (j*j*13 + f*29 + 200) % 256;
    end
    sharp  = (f >= 1 && f <= 3);
    smooth = (f == 4 || f == 5);
    pre    = (sharp && nout >= nin) || (smooth && nout < nin);   // R8
    post   = (sharp && nout < nin) || (smooth && nout >= nin);   // R8
    for (int k = 0; k < nout; k++) begin
      int p, e, t;
      p = (k * nin) / nout;                                      // R3
      if (post)     e = kern(f, rsm(k-1, nin, nout), rsm(k, nin, nout), rsm(k+1, nin, nout));
      else if (pre) e = kern(f, line_buf[clampi(p-1, 0, nin-1)], line_buf[p],
                             line_buf[clampi(p+1, 0, nin-1)]);
      else          e = line_buf[p];
      if (tag_ovr != 0)             t = tag_ovr;
      else if (!pre && !post)       t = 3;
      else if (k == 0 || k == nout-1) t = 9;
      else if (e == 0 || e == 255)  t = 7;
      else if (pre)                 t = 6;
      else                          t = 8;
      exp_q[wr] = e; tag_q[wr] = t; wr++;
    end
    for (int j = 0; j < nin; j++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_sol   = (j == 0);
      in_data  = 8'(line_buf[j]);
      if (j == 0) begin
        cfg_in_len = LW'(nin); cfg_out_len = LW'(nout); cfg_filter = 3'(f);
      end
      if (j == 1 && mess) begin   // R10: changes after in_sol are not used
        cfg_in_len = LW'(2); cfg_out_len = LW'(9); cfg_filter = 3'd5;
      end
      @(posedge clk);
    end
  endtask

  task automatic drain();
    int t = 0;
    while (rd < wr && t < 3000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int s;
    rst_n = 1'b0; in_valid = 1'b0; in_sol = 1'b0; in_data = '0;
    cfg_in_len = LW'(1); cfg_out_len = LW'(1); cfg_filter = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);

    // R1: samples without an open line are discarded
    cfg_in_len = LW'(2); cfg_out_len = LW'(4);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk); in_valid = 1'b1; in_sol = 1'b0; in_data = 8'(50 + j);
    end
    @(negedge clk) in_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(rd == 0, "R1 orphan outputs", rd, 0);
    chk(in_ready == 1'b1, "R1 ready after orphans", int'(in_ready), 1);

    // R10: restart by a second in_sol, then a line with late cfg changes
    @(negedge clk);
    in_valid = 1'b1; in_sol = 1'b1; in_data = 8'd11;
    cfg_in_len = LW'(8); cfg_out_len = LW'(5); cfg_filter = 3'd0;
    @(posedge clk);
    @(negedge clk) in_sol = 1'b0; in_data = 8'd22;
    @(posedge clk);
    send_line(5, 7, 4, 10, 1'b0);
    send_line(6, 4, 1, 10, 1'b1);
    drain();

    // R4: enlarging, outputs on consecutive cycles
    s = wr;
    send_line(3, 9, 0, 0, 1'b0);
    drain();
    for (int k = 0; k < 8; k++)
      chk(got_cyc[s+k+1] - got_cyc[s+k] == 1, "R4 gap", got_cyc[s+k+1] - got_cyc[s+k], 1);

    // R5: reducing, one input position per cycle
    s = wr;
    send_line(10, 3, 0, 0, 1'b0);
    drain();
    for (int k = 0; k < 2; k++) begin
      int g;
      g = ((k+1)*10)/3 - (k*10)/3;
      chk(got_cyc[s+k+1] - got_cyc[s+k] == g, "R5 gap", got_cyc[s+k+1] - got_cyc[s+k], g);
    end

    // sweep: back-to-back lines, trailing output meets next in_sol
    for (int f = 0; f < 8; f++)
      for (int ni = 1; ni <= ML; ni++)
        for (int no = 1; no <= ML; no++)
          send_line(ni, no, f, 0, 1'b0);
    @(negedge clk) in_valid = 1'b0; in_sol = 1'b0;
    drain();
    chk(rd == wr, "R2 total outputs", rd, wr);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule